// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation miss without software help. When a translation cache misses, the block takes the missing virtual page number and the kind of access being attempted. It forms the address of the matching entry in a single-level, linear page table, fetches that entry with one memory read, and inspects it.

A usable entry is written into the translation cache, and the block tells the requester to retry. An entry marked absent ends the walk with a segmentation fault. An entry whose permission bits do not allow the access ends it with a protection fault.

The block serves one walk at a time. Its miss port is open only while it is idle.

Top module: `ptw_walker`

## Requirements
- R1: The table-entry address is `ptbr + vpn*4`, taken modulo 2^PA_W. The base used is the value of `ptbr` in the cycle the miss is accepted; later changes to `ptbr` have no effect on that walk.
- R2: The read request is raised in the cycle after acceptance. Its valid and address stay constant until `mem_req_ready` is seen high. The walk issues exactly one request, and valid drops in the cycle after the handshake.
- R3: No outcome appears before a response. The block waits any number of cycles for `mem_rsp_valid`, and it captures `mem_rsp_data` in the single cycle where that signal is high.
- R4: If bit 31 (the present flag) of the fetched entry is 0, the walk ends with `fault_seg`, whatever the permission bits hold.
- R5: Permission bits are bit 30 (read), bit 29 (write) and bit 28 (execute). Access codes are 0 for read, 1 for write, 2 for execute and 3 reserved. A present entry whose bit for the access is 0, or any entry with access code 3, ends the walk with `fault_prot`.
- R6: Any other present entry raises `tlb_ins_valid`. In that cycle the insert port carries the walk's VPN, the frame number (entry bits 27:0) and the three permission bits, and `done_retry` is high at the same time.
- R7: Each walk raises exactly one of `done_retry`, `fault_seg` or `fault_prot`, and only for a single cycle. The outcome appears two cycles after the response cycle.
- R8: `miss_ready` is high only while the block is idle. A miss presented during a walk is ignored, and the block is idle again in the cycle after the outcome.
- R9: After reset the block is idle, with `miss_ready` high and every request, insert and outcome output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation miss presented |
| miss_ready | output | 1 | Block idle, miss accepted this cycle if valid |
| miss_vpn | input | VPN_W | Missing virtual page number |
| miss_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr | input | PA_W | Page-table base address |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | PA_W | Address of the table entry |
| mem_rsp_valid | input | 1 | Read data present this cycle |
| mem_rsp_data | input | DATA_W | Fetched table entry |
| tlb_ins_valid | output | 1 | Write translation into the cache |
| tlb_ins_vpn | output | VPN_W | Virtual page number to insert |
| tlb_ins_pfn | output | DATA_W-4 | Frame number to insert |
| tlb_ins_prot | output | 3 | Permission bits to insert |
| done_retry | output | 1 | Walk succeeded, retry the access |
| fault_seg | output | 1 | Entry not present |
| fault_prot | output | 1 | Access not permitted |

## Verification
Walks are run with entries that are absent, present with a forbidding bit, and present with an allowing bit. Each access code is paired with these entries, so the test shows whether the permission decode looks at the right bit and whether the present flag takes priority. The memory side is varied between immediate and stalled grants and between immediate and late responses, which separates a request that is held correctly from one that is dropped or moves. A base near the top of the address space checks the wrap of the address sum. Misses pushed in mid-walk, together with a base changed after acceptance, show whether state captured at acceptance can be disturbed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_CHECK,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_RETRY,
        OUT_SEG,
        OUT_PROT
    } outcome_e;

    localparam int PERM_W = 3;

    // perm[2]=read, perm[1]=write, perm[0]=execute
    function automatic logic perm_grants(logic [PERM_W-1:0] perm, acc_e acc);
        case (acc)
            ACC_READ:  return perm[2];
            ACC_WRITE: return perm[1];
            ACC_EXEC:  return perm[0];
            default:   return 1'b0;
        endcase
    endfunction

    function automatic outcome_e judge(logic present, logic [PERM_W-1:0] perm, acc_e acc);
        if (!present)
            return OUT_SEG;
        else if (!perm_grants(perm, acc))
            return OUT_PROT;
        else
            return OUT_RETRY;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VPN_W     = 20,
    parameter int PA_W      = 32,
    parameter int PTE_BYTES = 4
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int SHIFT = $clog2(PTE_BYTES);

    logic [PA_W-1:0] offset;

    always_comb begin
        offset     = PA_W'(vpn) << SHIFT;
        entry_addr = base + offset;
    end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PFN_W = DATA_W - 1 - PERM_W
) (
    input  logic [DATA_W-1:0] pte,
    input  acc_e              acc,
    output outcome_e          verdict,
    output logic [PFN_W-1:0]  pfn,
    output logic [PERM_W-1:0] perm
);
    logic present;

    always_comb begin
        present = pte[DATA_W-1];
        perm    = pte[DATA_W-2 -: PERM_W];
        pfn     = pte[PFN_W-1:0];
        verdict = judge(present, perm, acc);
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        miss_valid,
    input  logic        req_ready,
    input  logic        rsp_valid,
    output walk_state_e state
);
    walk_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (miss_valid) nxt = ST_ISSUE;
            ST_ISSUE: if (req_ready)  nxt = ST_WAIT;
            ST_WAIT:  if (rsp_valid)  nxt = ST_CHECK;
            ST_CHECK: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int PA_W      = 32,
    parameter int DATA_W    = 32,
    parameter int PTE_BYTES = 4,
    localparam int PFN_W    = DATA_W - 1 - PERM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [1:0]        miss_acc,
    input  logic [PA_W-1:0]   ptbr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              tlb_ins_valid,
    output logic [VPN_W-1:0]  tlb_ins_vpn,
    output logic [PFN_W-1:0]  tlb_ins_pfn,
    output logic [2:0]        tlb_ins_prot,
    output logic              done_retry,
    output logic              fault_seg,
    output logic              fault_prot
);
    walk_state_e       state;
    logic [VPN_W-1:0]  vpn_q;
    acc_e              acc_q;
    logic [PA_W-1:0]   addr_d, addr_q;
    logic [DATA_W-1:0] pte_q;
    outcome_e          verdict, outcome_q;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
    logic              accept;

    assign accept = (state == ST_IDLE) && miss_valid;

    ptw_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .state      (state)
    );

    ptw_addr_gen #(
        .VPN_W     (VPN_W),
        .PA_W      (PA_W),
        .PTE_BYTES (PTE_BYTES)
    ) u_addr (
        .vpn        (miss_vpn),
        .base       (ptbr),
        .entry_addr (addr_d)
    );

    ptw_pte_check #(
        .DATA_W (DATA_W)
    ) u_check (
        .pte     (pte_q),
        .acc     (acc_q),
        .verdict (verdict),
        .pfn     (pfn),
        .perm    (perm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q     <= '0;
            acc_q     <= ACC_READ;
            addr_q    <= '0;
            pte_q     <= '0;
            outcome_q <= OUT_NONE;
        end else begin
            if (accept) begin
                vpn_q  <= miss_vpn;
                acc_q  <= acc_e'(miss_acc);
                addr_q <= addr_d;
            end
            if (state == ST_WAIT && mem_rsp_valid)
                pte_q <= mem_rsp_data;
            if (state == ST_CHECK)
                outcome_q <= verdict;
            else if (state == ST_DONE)
                outcome_q <= OUT_NONE;
        end
    end

    always_comb begin
        miss_ready    = (state == ST_IDLE);
        mem_req_valid = (state == ST_ISSUE);
        mem_req_addr  = addr_q;
        done_retry    = (state == ST_DONE) && (outcome_q == OUT_RETRY);
        fault_seg     = (state == ST_DONE) && (outcome_q == OUT_SEG);
        fault_prot    = (state == ST_DONE) && (outcome_q == OUT_PROT);
        tlb_ins_valid = done_retry;
        tlb_ins_vpn   = vpn_q;
        tlb_ins_pfn   = pfn;
        tlb_ins_prot  = perm;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            miss_valid,
    input logic            miss_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            tlb_ins_valid,
    input logic            done_retry,
    input logic            fault_seg,
    input logic            fault_prot
);
    logic any_out;
    assign any_out = done_retry | fault_seg | fault_prot;

    a_r2_hold_request: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r2_single_request: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $countones({done_retry, fault_seg, fault_prot}) <= 1);

    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        any_out |=> !any_out && miss_ready);

    a_r6_insert_with_retry: assert property (@(posedge clk) disable iff (rst)
        tlb_ins_valid == done_retry);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        miss_valid && miss_ready |=> !miss_ready && mem_req_valid);

    a_r3_no_outcome_while_requesting: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !any_out && !mem_rsp_valid || !any_out);

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> miss_ready && !mem_req_valid && !any_out);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .tlb_ins_valid (tlb_ins_valid),
    .done_retry    (done_retry),
    .fault_seg     (fault_seg),
    .fault_prot    (fault_prot)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 0;
    logic        rst;
    logic        miss_valid, miss_ready;
    logic [19:0] miss_vpn;
    logic [1:0]  miss_acc;
    logic [31:0] ptbr;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        tlb_ins_valid;
    logic [19:0] tlb_ins_vpn;
    logic [27:0] tlb_ins_pfn;
    logic [2:0]  tlb_ins_prot;
    logic        done_retry, fault_seg, fault_prot;

    int checks = 0;
    int fails  = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vpn(miss_vpn), .miss_acc(miss_acc), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .tlb_ins_valid(tlb_ins_valid), .tlb_ins_vpn(tlb_ins_vpn),
        .tlb_ins_pfn(tlb_ins_pfn), .tlb_ins_prot(tlb_ins_prot),
        .done_retry(done_retry), .fault_seg(fault_seg), .fault_prot(fault_prot)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    // 1 = retry, 2 = segmentation fault, 3 = protection fault
    function automatic int expect_out(logic [31:0] pte, logic [1:0] acc);
        logic ok;
        if (!pte[31]) return 2;
        case (acc)
            2'd0: ok = pte[30];
            2'd1: ok = pte[29];
            2'd2: ok = pte[28];
            default: ok = 1'b0;
        endcase
        return ok ? 1 : 3;
    endfunction

    task automatic walk(string tag, logic [19:0] vpn, logic [1:0] acc, logic [31:0] base,
                        logic [31:0] pte, int stall, int dly, bit junk);
        logic [31:0] exp_addr;
        int eo;
        exp_addr = base + ({12'd0, vpn} << 2);
        eo = expect_out(pte, acc);
        @(negedge clk);
        check("R8", {tag, " idle ready"}, miss_ready, 1);
        miss_valid = 1; miss_vpn = vpn; miss_acc = acc; ptbr = base;
        @(negedge clk);
        miss_valid = 0; ptbr = ~base;
        check("R8", {tag, " busy"}, miss_ready, 0);
        check("R2", {tag, " req valid"}, mem_req_valid, 1);
        check("R1", {tag, " addr"}, mem_req_addr, exp_addr);
        for (int i = 0; i < stall; i++) begin
            if (junk) begin miss_valid = 1; miss_vpn = ~vpn; miss_acc = ~acc; end
            mem_req_ready = 0;
            @(negedge clk);
            check("R2", {tag, " held valid"}, mem_req_valid, 1);
            check("R2", {tag, " held addr"}, mem_req_addr, exp_addr);
        end
        miss_valid = 0;
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        check("R2", {tag, " req dropped"}, mem_req_valid, 0);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check("R3", {tag, " no early outcome"}, {done_retry, fault_seg, fault_prot}, 0);
            check("R2", {tag, " no second req"}, mem_req_valid, 0);
        end
        mem_rsp_valid = 1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
        check("R3", {tag, " no outcome at check"}, {done_retry, fault_seg, fault_prot}, 0);
        @(negedge clk);
        check("R6", {tag, " retry"}, done_retry, eo == 1);
        check("R4", {tag, " segfault"}, fault_seg, eo == 2);
        check("R5", {tag, " protfault"}, fault_prot, eo == 3);
        check("R6", {tag, " insert valid"}, tlb_ins_valid, eo == 1);
        if (eo == 1) begin
            check("R6", {tag, " ins vpn"}, tlb_ins_vpn, vpn);
            check("R6", {tag, " ins pfn"}, tlb_ins_pfn, pte[27:0]);
            check("R6", {tag, " ins prot"}, tlb_ins_prot, pte[30:28]);
        end
        @(negedge clk);
        check("R7", {tag, " single pulse"}, {done_retry, fault_seg, fault_prot, tlb_ins_valid}, 0);
        check("R8", {tag, " idle again"}, miss_ready, 1);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R9", "ready after reset", miss_ready, 1);
        check("R9", "no request after reset", mem_req_valid, 0);
        check("R9", "no outputs after reset",
              {done_retry, fault_seg, fault_prot, tlb_ins_valid}, 0);
    endtask

    task automatic t_success();
        walk("R6 read ok", 20'h00AA1, 2'd0, 32'h0001_0000, 32'hC123_4567, 0, 0, 0);
        walk("R6 write ok stalled", 20'h12345, 2'd1, 32'h8000_0000, 32'hA0AB_CDEF, 3, 2, 0);
        walk("R6 exec ok", 20'hFFFFF, 2'd2, 32'h0000_1000, 32'h9000_0091, 1, 4, 0);
    endtask

    task automatic t_segfault();
        walk("R4 absent all perms", 20'h00005, 2'd0, 32'h0002_0000, 32'h7FFF_FFFF, 0, 1, 0);
        walk("R4 absent reserved", 20'h00006, 2'd3, 32'h0002_0000, 32'h7000_0012, 0, 0, 0);
    endtask

    task automatic t_protfault();
        walk("R5 write read-only", 20'h000BB, 2'd1, 32'h0004_0000, 32'hC000_0091, 2, 0, 0);
        walk("R5 exec no x", 20'h000FF, 2'd2, 32'h0004_0000, 32'hE000_0023, 0, 3, 0);
        walk("R5 read write-only", 20'h00010, 2'd0, 32'h0004_0000, 32'hA000_0001, 0, 0, 0);
        walk("R5 reserved code", 20'h00011, 2'd3, 32'h0004_0000, 32'hF000_0002, 0, 0, 0);
    endtask

    task automatic t_wrap_and_busy();
        walk("R1 wrap", 20'h00008, 2'd0, 32'hFFFF_FFF0, 32'hC000_0055, 0, 0, 0);
        walk("R8 miss during walk ignored", 20'h0ABCD, 2'd1, 32'h0010_0000, 32'hE000_0777, 4, 1, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        miss_valid = 0; miss_vpn = 0; miss_acc = 0; ptbr = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        t_reset();
        t_success();
        t_segfault();
        t_protfault();
        t_wrap_and_busy();
        report();
        $finish;
    end
endmodule